// File: doc/BRIEF.md
# Double-width funnel shift unit

This execution unit serves two three-operand shift instructions. Each one joins a high word and a low word into a 128-bit value and returns one 64-bit slice of it. The shift-left form returns the upper half of the joined value after a left shift. The shift-right form returns the lower half after a right shift. Multi-word integer code uses these to move a bit stream across word boundaries in a single operation per word.

The unit receives the 32-bit instruction word and the three operand values that have already been read from the register file. The high word comes from the register named in the fourth register field, the low word from the second field, and the shift amount from the third field. The unit decodes the opcode fields and selects the direction and the record option. One cycle later it presents the result. When the record bit is set, it also presents a 4-bit signed-versus-zero condition field with a write strobe. Instruction words that do not belong to the unit are flagged as illegal, and no result is produced for them.

Top module: `dwshift_unit`

## Requirements
- R1: Bits are numbered LSB-0 on the `instr` port. The primary opcode is `instr[31:26]` and must equal 4. The extended opcode is `instr[5:1]`: 26 selects the left shift and 27 selects the right shift. The record bit is `instr[0]`. `instr[25:6]` (register indices) do not affect the operation.
- R2: For the left shift, `result` equals bits 127..64 of `{src_hi, src_lo} << n`.
- R3: For the right shift, `result` equals bits 63..0 of `{src_hi, src_lo} >> n`.
- R4: The shift count n is `src_amt[5:0]`; every higher bit of `src_amt` has no effect on `result`.
- R5: When n is 0, the left shift returns `src_hi` unchanged and the right shift returns `src_lo` unchanged.
- R6: When the record bit is 1, `cr_we` is 1 together with `out_valid`. `cr_field` is {LT, GT, EQ, 0} in bits 3..0, from a signed comparison of the result with zero, with exactly one of bits 3..1 set.
- R7: When the record bit is 0, `cr_we` stays 0 and `cr_field` keeps its previous value.
- R8: An instruction with any other primary or extended opcode sets `illegal` for one cycle. In that cycle `out_valid` and `cr_we` are 0, and `result` keeps its previous value.
- R9: `out_valid` or `illegal` rises exactly one clock after a cycle with `in_valid` high. Neither is ever high one cycle after a cycle with `in_valid` low.
- R10: A synchronous active-high reset clears `out_valid`, `illegal`, `cr_we`, `result` and `cr_field` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands are present this cycle |
| instr | input | 32 | Instruction word |
| src_hi | input | 64 | High word (fourth register field) |
| src_lo | input | 64 | Low word (second register field) |
| src_amt | input | 64 | Shift amount (third register field) |
| out_valid | output | 1 | Result is valid this cycle |
| result | output | 64 | Shifted result word |
| cr_field | output | 4 | Condition field {LT, GT, EQ, 0} |
| cr_we | output | 1 | Condition field write enable |
| illegal | output | 1 | Instruction word was not a supported opcode |

## Verification
The checks assume that `in_valid` and `rst` are driven to known levels from the first clock edge. They also assume the operand values are stable in every cycle where `in_valid` is high, because the zero-count check compares the result against the high word sampled one cycle earlier. The stimulus changes every input only on the falling clock edge and holds `in_valid` at 0 throughout reset. It never issues back-to-back strobes without a fully defined instruction word and operand set. The result-retention checks on illegal and record-free instructions depend on the previous legal result, so the stimulus always places a known legal operation immediately before them.

// File: rtl/dwshift_pkg.sv
package dwshift_pkg;

  typedef enum logic [1:0] {
    DS_NONE = 2'd0,
    DS_SHL  = 2'd1,
    DS_SHR  = 2'd2
  } dshift_op_e;

  localparam int unsigned DS_PO_W = 6;
  localparam int unsigned DS_XO_W = 5;

endpackage

// File: rtl/dwshift_decode.sv
module dwshift_decode #(
  parameter int unsigned IW     = 32,
  parameter int unsigned PO_VAL = 4,
  parameter int unsigned XO_SHL = 26,
  parameter int unsigned XO_SHR = 27
) (
  input  logic [IW-1:0]           instr,
  output dwshift_pkg::dshift_op_e op,
  output logic                    rec
);
  import dwshift_pkg::*;

  localparam int unsigned PO_W = DS_PO_W;
  localparam int unsigned XO_W = DS_XO_W;

  logic [PO_W-1:0] po;
  logic [XO_W-1:0] xo;
  logic [IW-PO_W-XO_W-2:0] fields_unused;

  assign po            = instr[IW-1 -: PO_W];
  assign xo            = instr[XO_W:1];
  assign rec           = instr[0];
  assign fields_unused = instr[IW-PO_W-1:XO_W+1];

  always_comb begin
    op = DS_NONE;
    if (po == PO_W'(PO_VAL)) begin
      if (xo == XO_W'(XO_SHL))      op = DS_SHL;
      else if (xo == XO_W'(XO_SHR)) op = DS_SHR;
    end
  end

endmodule

// File: rtl/dwshift_core.sv
module dwshift_core #(
  parameter int unsigned XLEN = 64,
  localparam int unsigned SHW = $clog2(XLEN)
) (
  input  logic            dir_left,
  input  logic [XLEN-1:0] hi,
  input  logic [XLEN-1:0] lo,
  input  logic [SHW-1:0]  n,
  output logic [XLEN-1:0] res
);

  logic [XLEN-1:0] mask_l, mask_r, merged;
  logic [SHW-1:0]  rot;
  logic [XLEN-1:0] stg [SHW+1];

  // Merge: keep the bits that survive from each word, then rotate into place.
  assign mask_l = {XLEN{1'b1}} >> n;
  assign mask_r = {XLEN{1'b1}} << n;
  assign merged = dir_left ? ((hi & mask_l) | (lo & ~mask_l))
                           : ((hi & ~mask_r) | (lo & mask_r));
  // A right rotate by n is a left rotate by (XLEN - n) mod XLEN.
  assign rot    = dir_left ? n : (SHW'(0) - n);

  assign stg[0] = merged;
  for (genvar g = 0; g < SHW; g++) begin : g_rot
    localparam int unsigned K = 1 << g;
    assign stg[g+1] = rot[g] ? {stg[g][XLEN-1-K:0], stg[g][XLEN-1 -: K]}
                             : stg[g];
  end
  assign res = stg[SHW];

endmodule

// File: rtl/dwshift_flags.sv
module dwshift_flags #(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] value,
  output logic [3:0]      cr
);
  logic neg, zero, pos;

  assign neg  = value[XLEN-1];
  assign zero = (value == '0);
  assign pos  = !neg && !zero;
  assign cr   = {neg, pos, zero, 1'b0};

endmodule

// File: rtl/dwshift_unit.sv
module dwshift_unit #(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned IW     = 32,
  parameter int unsigned PO_VAL = 4,
  parameter int unsigned XO_SHL = 26,
  parameter int unsigned XO_SHR = 27
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [IW-1:0]   instr,
  input  logic [XLEN-1:0] src_hi,
  input  logic [XLEN-1:0] src_lo,
  input  logic [XLEN-1:0] src_amt,
  output logic            out_valid,
  output logic [XLEN-1:0] result,
  output logic [3:0]      cr_field,
  output logic            cr_we,
  output logic            illegal
);
  import dwshift_pkg::*;

  localparam int unsigned SHW = $clog2(XLEN);

  dshift_op_e      op;
  logic            rec, legal;
  logic [SHW-1:0]  n;
  logic [XLEN-SHW-1:0] amt_unused_bits;
  logic [XLEN-1:0] res_c;
  logic [3:0]      cr_c;

  logic            vld_q, ill_q, we_q;
  logic [XLEN-1:0] res_q;
  logic [3:0]      cr_q;

  assign n               = src_amt[SHW-1:0];
  assign amt_unused_bits = src_amt[XLEN-1:SHW];
  assign legal           = (op != DS_NONE);

  dwshift_decode #(
    .IW(IW), .PO_VAL(PO_VAL), .XO_SHL(XO_SHL), .XO_SHR(XO_SHR)
  ) u_dec (
    .instr(instr), .op(op), .rec(rec)
  );

  dwshift_core #(.XLEN(XLEN)) u_core (
    .dir_left(op == DS_SHL), .hi(src_hi), .lo(src_lo), .n(n), .res(res_c)
  );

  dwshift_flags #(.XLEN(XLEN)) u_flags (
    .value(res_c), .cr(cr_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      ill_q <= 1'b0;
      we_q  <= 1'b0;
      res_q <= '0;
      cr_q  <= '0;
    end else begin
      vld_q <= in_valid && legal;
      ill_q <= in_valid && !legal;
      we_q  <= in_valid && legal && rec;
      if (in_valid && legal)        res_q <= res_c;
      if (in_valid && legal && rec) cr_q  <= cr_c;
    end
  end

  assign out_valid = vld_q;
  assign illegal   = ill_q;
  assign cr_we     = we_q;
  assign result    = res_q;
  assign cr_field  = cr_q;

  // R9: any output strobe traces back to an input strobe one cycle earlier
  a_r9_strobe_latency: assert property (@(posedge clk) disable iff (rst)
    (out_valid || illegal) |-> $past(in_valid));

  // R8: illegal and a valid result never coincide
  a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && illegal));

  // R7: a condition write only accompanies a valid result
  a_r7_we_with_valid: assert property (@(posedge clk) disable iff (rst)
    cr_we |-> out_valid);

  // R6: exactly one of LT/GT/EQ, low bit zero
  a_r6_flags_onehot: assert property (@(posedge clk) disable iff (rst)
    cr_we |-> ($countones(cr_field[3:1]) == 1 && !cr_field[0]));

  // R8: result held across an illegal instruction
  a_r8_result_held: assert property (@(posedge clk) disable iff (rst)
    illegal |-> $stable(result));

  // R5: zero-count left shift passes the high word through
  a_r5_zero_left: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == DS_SHL && n == '0) |=> (result == $past(src_hi)));

  // R10: reset clears the strobes
  a_r10_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && !illegal && !cr_we));

endmodule

// File: tb/dwshift_unit_tb.sv
`timescale 1ns/1ps
module dwshift_unit_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] src_hi = '0, src_lo = '0, src_amt = '0;
  logic        out_valid, cr_we, illegal;
  logic [63:0] result;
  logic [3:0]  cr_field;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  dwshift_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .src_hi(src_hi), .src_lo(src_lo), .src_amt(src_amt),
    .out_valid(out_valid), .result(result), .cr_field(cr_field),
    .cr_we(cr_we), .illegal(illegal)
  );

  localparam logic [63:0] HA = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] LA = 64'hFEDC_BA98_7654_3210;

  function automatic logic [31:0] mk(input logic [5:0] po, input logic [4:0] xo, input logic rc);
    return {po, 5'd3, 5'd4, 5'd5, 5'd6, xo, rc};
  endfunction

  function automatic logic [63:0] ref_l(input logic [63:0] h, input logic [63:0] l, input logic [63:0] a);
    logic [127:0] t;
    t = {h, l} << a[5:0];
    return t[127:64];
  endfunction

  function automatic logic [63:0] ref_r(input logic [63:0] h, input logic [63:0] l, input logic [63:0] a);
    logic [127:0] t;
    t = {h, l} >> a[5:0];
    return t[63:0];
  endfunction

  function automatic logic [3:0] ref_cr(input logic [63:0] v);
    if ($signed(v) < 0)      return 4'b1000;
    else if ($signed(v) > 0) return 4'b0100;
    else                     return 4'b0010;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one instruction: drive at falling edge, registered outputs ready at next falling edge
  task automatic issue(input logic [31:0] iw, input logic [63:0] h, input logic [63:0] l, input logic [63:0] a);
    @(negedge clk);
    instr = iw; src_hi = h; src_lo = l; src_amt = a; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R10 out_valid", 64'(out_valid), 64'd0);
    chk("R10 illegal", 64'(illegal), 64'd0);
    chk("R10 cr_we", 64'(cr_we), 64'd0);
    chk("R10 result", result, 64'd0);
    chk("R10 cr_field", 64'(cr_field), 64'd0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_left;
    int amts[5] = '{1, 4, 31, 32, 63};
    foreach (amts[i]) begin
      issue(mk(6'd4, 5'd26, 1'b0), HA, LA, 64'(amts[i]));
      chk("R2 valid", 64'(out_valid), 64'd1);
      chk("R2 left result", result, ref_l(HA, LA, 64'(amts[i])));
    end
  endtask

  task automatic t_right;
    int amts[5] = '{1, 8, 31, 32, 63};
    foreach (amts[i]) begin
      issue(mk(6'd4, 5'd27, 1'b0), HA, LA, 64'(amts[i]));
      chk("R3 valid", 64'(out_valid), 64'd1);
      chk("R3 right result", result, ref_r(HA, LA, 64'(amts[i])));
    end
  endtask

  task automatic t_zero;
    issue(mk(6'd4, 5'd26, 1'b0), HA, LA, 64'd0);
    chk("R5 left n=0", result, HA);
    issue(mk(6'd4, 5'd27, 1'b0), HA, LA, 64'd0);
    chk("R5 right n=0", result, LA);
  endtask

  task automatic t_amount_high;
    issue(mk(6'd4, 5'd26, 1'b0), HA, LA, 64'hFFFF_FFFF_FFFF_FFC5);
    chk("R4 left high bits", result, ref_l(HA, LA, 64'd5));
    issue(mk(6'd4, 5'd27, 1'b0), HA, LA, 64'h8000_0000_0000_0047);
    chk("R4 right high bits", result, ref_r(HA, LA, 64'd7));
    issue(mk(6'd4, 5'd26, 1'b0), HA, LA, 64'd64);
    chk("R4 amount 64 acts as 0", result, HA);
  endtask

  task automatic t_flags;
    logic [63:0] e;
    issue(mk(6'd4, 5'd26, 1'b1), 64'd0, LA, 64'd0);
    chk("R6 eq we", 64'(cr_we), 64'd1);
    chk("R6 eq field", 64'(cr_field), 64'(ref_cr(64'd0)));
    issue(mk(6'd4, 5'd27, 1'b1), 64'd0, 64'h8000_0000_0000_0000, 64'd0);
    chk("R6 lt field", 64'(cr_field), 64'h8);
    e = ref_r(HA, LA, 64'd4);
    issue(mk(6'd4, 5'd27, 1'b1), HA, LA, 64'd4);
    chk("R6 rec result", result, e);
    chk("R6 computed field", 64'(cr_field), 64'(ref_cr(e)));
    issue(mk(6'd4, 5'd26, 1'b1), 64'h7, 64'd0, 64'd0);
    chk("R6 gt field", 64'(cr_field), 64'h4);
  endtask

  task automatic t_norec;
    // previous field is GT from t_flags
    issue(mk(6'd4, 5'd26, 1'b0), 64'd0, 64'd0, 64'd0);
    chk("R7 no write", 64'(cr_we), 64'd0);
    chk("R7 field kept", 64'(cr_field), 64'h4);
    chk("R7 result still written", result, 64'd0);
  endtask

  task automatic t_illegal;
    logic [63:0] keep;
    issue(mk(6'd4, 5'd26, 1'b1), HA, LA, 64'd12);
    keep = ref_l(HA, LA, 64'd12);
    chk("R8 setup", result, keep);
    issue(mk(6'd5, 5'd26, 1'b1), LA, HA, 64'd3);
    chk("R8 illegal po", 64'(illegal), 64'd1);
    chk("R8 no valid", 64'(out_valid), 64'd0);
    chk("R8 no cr write", 64'(cr_we), 64'd0);
    chk("R8 result kept", result, keep);
    issue(mk(6'd4, 5'd28, 1'b0), LA, HA, 64'd3);
    chk("R8 illegal xo", 64'(illegal), 64'd1);
    chk("R8 result kept xo", result, keep);
    issue(mk(6'd4, 5'd25, 1'b1), LA, HA, 64'd3);
    chk("R8 illegal xo low", 64'(illegal), 64'd1);
  endtask

  task automatic t_fields_and_latency;
    // R1: register index bits differ, operation unchanged
    @(negedge clk);
    instr = {6'd4, 20'hABCDE, 5'd27, 1'b0}; src_hi = HA; src_lo = LA; src_amt = 64'd9; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1 index bits ignored", result, ref_r(HA, LA, 64'd9));
    chk("R1 decode valid", 64'(out_valid), 64'd1);
    @(negedge clk);
    chk("R9 single pulse", 64'(out_valid), 64'd0);
    chk("R9 no illegal idle", 64'(illegal), 64'd0);
    // R9: inputs change with in_valid low produce nothing
    instr = mk(6'd4, 5'd26, 1'b1); src_hi = LA;
    @(negedge clk);
    chk("R9 idle no valid", 64'(out_valid), 64'd0);
    chk("R9 idle no we", 64'(cr_we), 64'd0);
  endtask

  task automatic finish_run;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    t_reset();
    t_left();
    t_right();
    t_zero();
    t_amount_high();
    t_flags();
    t_norec();
    t_illegal();
    t_fields_and_latency();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule